// File: doc/BRIEF.md
# Blocking Two-Port Request Forwarder

This block connects two requester ports, an instruction port (index 0) and a data port (index 1), to a single memory port. It accepts one request at a time, passes it to memory, and returns the memory's response to the requester that issued it. It is fully blocking. From the moment a request is accepted until memory hands back the response, the block is *blocked*, and any new request is refused.

Every port uses the same one-cycle offer model. A sender raises `valid` for one cycle. The receiver accepts by holding `ready` high in that cycle, or refuses by holding it low. After a refusal, the sender keeps the packet and does not offer it again until it sees a one-cycle retry pulse. Toward requesters, the block remembers which ports it refused and pulses `req_retry` for them once it unblocks. Toward memory and toward each requester's response path, the block keeps a single held packet and re-offers it after the matching retry pulse. A packet is an address, a write flag and a data word.

The control FSM has four states: `CT_IDLE` (not blocked), `CT_ISSUE` (offering to memory), `CT_STALL` (memory refused; holding) and `CT_AWAIT` (waiting for the response). Its transitions are: accept (IDLE→ISSUE), mem-accept (ISSUE→AWAIT), mem-refuse (ISSUE→STALL), mem-retry (STALL→ISSUE) and rsp-taken (AWAIT→IDLE). Each response port has three states: `RP_EMPTY`, `RP_OFFER` and `RP_HELD`. Its transitions are: load (EMPTY→OFFER), taken (OFFER→EMPTY), refused (OFFER→HELD) and retry (HELD→OFFER).

Top module: `reqfwd_top`

## Requirements
- R1: After reset the block is not blocked, so `req_ready` is 2'b11 with no request present. `mem_req_valid`, `rsp_valid`, `req_retry` and `mem_rsp_ready` are all 0.
- R2: A request offered while not blocked is accepted in the same cycle. In the next cycle it is offered to memory with the same address, write flag and data.
- R3: If both requesters offer in the same non-blocked cycle, the data port (index 1) is accepted and the instruction port (index 0) is refused.
- R4: From the cycle after an accept until the cycle in which memory's response is accepted, both `req_ready` bits are 0, so every request offered in that window is refused.
- R5: Each requester port refused since the last unblock receives exactly one `req_retry` pulse, in the cycle after memory's response is accepted. A port that was not refused receives no pulse.
- R6: If memory refuses the offered request, `mem_req_valid` stays 0 until `mem_req_retry` is seen. The same packet is re-offered in the cycle after that retry pulse.
- R7: A response accepted from memory is offered in the next cycle on the port that issued the request, with memory's address, write flag and data. The other port's `rsp_valid` stays 0.
- R8: If a requester refuses its response, that port's `rsp_valid` stays 0 until its `rsp_retry` pulse. The held response is re-offered in the cycle after that pulse.
- R9: The blocked state ends when memory's response is accepted, so `req_ready` is high again in the next cycle.
- R10: `mem_rsp_ready` is 1 only while awaiting a response and the owner port's response buffer is empty. A still-undelivered earlier response on that port holds memory's response off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Request offer per requester (0 instr, 1 data) |
| req_addr | input | 2×ADDR_W | Request address per requester |
| req_wr | input | 2 | Request write flag per requester |
| req_data | input | 2×DATA_W | Request data per requester |
| req_ready | output | 2 | Request accepted this cycle |
| req_retry | output | 2 | One-cycle pulse: refused requester may try again |
| rsp_valid | output | 2 | Response offer per requester |
| rsp_addr | output | 2×ADDR_W | Response address per requester |
| rsp_wr | output | 2 | Response write flag per requester |
| rsp_data | output | 2×DATA_W | Response data per requester |
| rsp_ready | input | 2 | Requester accepts its response this cycle |
| rsp_retry | input | 2 | Requester asks for its held response again |
| mem_req_valid | output | 1 | Request offer to memory |
| mem_req_addr | output | ADDR_W | Forwarded address |
| mem_req_wr | output | 1 | Forwarded write flag |
| mem_req_data | output | DATA_W | Forwarded data |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_retry | input | 1 | Memory asks for the held request again |
| mem_rsp_valid | input | 1 | Response offer from memory |
| mem_rsp_addr | input | ADDR_W | Response address |
| mem_rsp_wr | input | 1 | Response write flag |
| mem_rsp_data | input | DATA_W | Response data |
| mem_rsp_ready | output | 1 | Block accepts memory's response this cycle |

## Verification
A control FSM stuck in a blocked state shows up within one cycle of the expected unblock: `req_ready` stays low, and no `req_retry` pulse appears. A lost owner index sends the response to the wrong port in the cycle right after memory hands it over. A response-port FSM that forgets its held packet, or re-offers it without a retry, shows up on `rsp_valid` one cycle after the refusal or the retry. The same applies to the memory request path through `mem_req_valid`. Each of these is sampled at its exact expected cycle.

// File: rtl/reqfwd_pkg.sv
package reqfwd_pkg;
    localparam int NUM_REQ    = 2;
    localparam int PORT_INSTR = 0;
    localparam int PORT_DATA  = 1;

    typedef enum logic [1:0] {
        CT_IDLE,
        CT_ISSUE,
        CT_STALL,
        CT_AWAIT
    } ctl_state_e;

    typedef enum logic [1:0] {
        RP_EMPTY,
        RP_OFFER,
        RP_HELD
    } rsp_state_e;
endpackage

// File: rtl/reqfwd_arb.sv
module reqfwd_arb
    import reqfwd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_REQ-1:0] req_valid,
    input  logic               blocked,
    input  logic               unblock,
    output logic [NUM_REQ-1:0] req_ready,
    output logic               accept,
    output logic               grant_idx,
    output logic [NUM_REQ-1:0] req_retry
);
    logic [NUM_REQ-1:0] owed_q;
    logic [NUM_REQ-1:0] refuse;

    always_comb begin
        req_ready[PORT_DATA]  = !blocked;
        req_ready[PORT_INSTR] = !blocked && !req_valid[PORT_DATA];
        refuse    = req_valid & ~req_ready;
        accept    = |(req_valid & req_ready);
        grant_idx = req_valid[PORT_DATA];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owed_q    <= '0;
            req_retry <= '0;
        end else if (unblock) begin
            req_retry <= owed_q | refuse;
            owed_q    <= '0;
        end else begin
            req_retry <= '0;
            owed_q    <= owed_q | refuse;
        end
    end
endmodule

// File: rtl/reqfwd_ctrl.sv
module reqfwd_ctrl
    import reqfwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            accept,
    input  logic                            grant_idx,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NUM_REQ-1:0]              req_wr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]  req_data,
    input  logic                            mem_req_ready,
    input  logic                            mem_req_retry,
    input  logic                            mem_rsp_valid,
    input  logic [NUM_REQ-1:0]              rsp_free,
    output logic                            blocked,
    output logic                            unblock,
    output logic [NUM_REQ-1:0]              deliver,
    output logic                            mem_req_valid,
    output logic [ADDR_W-1:0]               mem_req_addr,
    output logic                            mem_req_wr,
    output logic [DATA_W-1:0]               mem_req_data,
    output logic                            mem_rsp_ready
);
    ctl_state_e state_q, state_d;
    logic       owner_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CT_IDLE:  if (accept)        state_d = CT_ISSUE;
            CT_ISSUE: state_d = mem_req_ready ? CT_AWAIT : CT_STALL;
            CT_STALL: if (mem_req_retry) state_d = CT_ISSUE;
            CT_AWAIT: if (unblock)       state_d = CT_IDLE;
            default:  state_d = CT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= CT_IDLE;
            owner_q      <= 1'b0;
            mem_req_addr <= '0;
            mem_req_wr   <= 1'b0;
            mem_req_data <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == CT_IDLE && accept) begin
                owner_q      <= grant_idx;
                mem_req_addr <= req_addr[grant_idx];
                mem_req_wr   <= req_wr[grant_idx];
                mem_req_data <= req_data[grant_idx];
            end
        end
    end

    always_comb begin
        blocked       = (state_q != CT_IDLE);
        mem_req_valid = (state_q == CT_ISSUE);
        mem_rsp_ready = (state_q == CT_AWAIT) && rsp_free[owner_q];
        unblock       = mem_rsp_ready && mem_rsp_valid;
        for (int i = 0; i < NUM_REQ; i++) begin
            deliver[i] = unblock && (owner_q == i[0]);
        end
    end
endmodule

// File: rtl/reqfwd_rsp_port.sv
module reqfwd_rsp_port
    import reqfwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_wr,
    input  logic [DATA_W-1:0] in_data,
    input  logic              rsp_ready,
    input  logic              rsp_retry,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_wr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              free
);
    rsp_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_EMPTY: if (load)      state_d = RP_OFFER;
            RP_OFFER: state_d = rsp_ready ? RP_EMPTY : RP_HELD;
            RP_HELD:  if (rsp_retry) state_d = RP_OFFER;
            default:  state_d = RP_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= RP_EMPTY;
            rsp_addr <= '0;
            rsp_wr   <= 1'b0;
            rsp_data <= '0;
        end else begin
            state_q <= state_d;
            if (load && state_q == RP_EMPTY) begin
                rsp_addr <= in_addr;
                rsp_wr   <= in_wr;
                rsp_data <= in_data;
            end
        end
    end

    always_comb begin
        rsp_valid = (state_q == RP_OFFER);
        free      = (state_q == RP_EMPTY);
    end
endmodule

// File: rtl/reqfwd_top.sv
module reqfwd_top
    import reqfwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_REQ-1:0]              req_valid,
    input  logic [NUM_REQ-1:0][ADDR_W-1:0]  req_addr,
    input  logic [NUM_REQ-1:0]              req_wr,
    input  logic [NUM_REQ-1:0][DATA_W-1:0]  req_data,
    output logic [NUM_REQ-1:0]              req_ready,
    output logic [NUM_REQ-1:0]              req_retry,
    output logic [NUM_REQ-1:0]              rsp_valid,
    output logic [NUM_REQ-1:0][ADDR_W-1:0]  rsp_addr,
    output logic [NUM_REQ-1:0]              rsp_wr,
    output logic [NUM_REQ-1:0][DATA_W-1:0]  rsp_data,
    input  logic [NUM_REQ-1:0]              rsp_ready,
    input  logic [NUM_REQ-1:0]              rsp_retry,
    output logic                            mem_req_valid,
    output logic [ADDR_W-1:0]               mem_req_addr,
    output logic                            mem_req_wr,
    output logic [DATA_W-1:0]               mem_req_data,
    input  logic                            mem_req_ready,
    input  logic                            mem_req_retry,
    input  logic                            mem_rsp_valid,
    input  logic [ADDR_W-1:0]               mem_rsp_addr,
    input  logic                            mem_rsp_wr,
    input  logic [DATA_W-1:0]               mem_rsp_data,
    output logic                            mem_rsp_ready
);
    logic               blocked;
    logic               unblock;
    logic               accept;
    logic               grant_idx;
    logic [NUM_REQ-1:0] deliver;
    logic [NUM_REQ-1:0] rsp_free;

    reqfwd_arb u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .blocked   (blocked),
        .unblock   (unblock),
        .req_ready (req_ready),
        .accept    (accept),
        .grant_idx (grant_idx),
        .req_retry (req_retry)
    );

    reqfwd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept        (accept),
        .grant_idx     (grant_idx),
        .req_addr      (req_addr),
        .req_wr        (req_wr),
        .req_data      (req_data),
        .mem_req_ready (mem_req_ready),
        .mem_req_retry (mem_req_retry),
        .mem_rsp_valid (mem_rsp_valid),
        .rsp_free      (rsp_free),
        .blocked       (blocked),
        .unblock       (unblock),
        .deliver       (deliver),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wr    (mem_req_wr),
        .mem_req_data  (mem_req_data),
        .mem_rsp_ready (mem_rsp_ready)
    );

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_rsp
        reqfwd_rsp_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (deliver[g]),
            .in_addr   (mem_rsp_addr),
            .in_wr     (mem_rsp_wr),
            .in_data   (mem_rsp_data),
            .rsp_ready (rsp_ready[g]),
            .rsp_retry (rsp_retry[g]),
            .rsp_valid (rsp_valid[g]),
            .rsp_addr  (rsp_addr[g]),
            .rsp_wr    (rsp_wr[g]),
            .rsp_data  (rsp_data[g]),
            .free      (rsp_free[g])
        );
    end
endmodule

// File: rtl/reqfwd_chk.sv
module reqfwd_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_valid,
    input logic [1:0] req_ready,
    input logic [1:0] req_retry,
    input logic [1:0] rsp_valid,
    input logic [1:0] rsp_ready,
    input logic       mem_req_valid,
    input logic       mem_req_ready,
    input logic       mem_rsp_valid,
    input logic       mem_rsp_ready
);
    // R3
    data_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid == 2'b11) |-> !req_ready[0]);

    // R4
    block_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(req_valid & req_ready)) |=> (req_ready == 2'b00));

    // R4
    no_ready_while_forwarding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (req_ready == 2'b00));

    // R5
    retry_after_unblock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_retry != 2'b00) |-> $past(mem_rsp_valid && mem_rsp_ready));

    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> !mem_req_valid);

    // R7
    rsp_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rsp_valid && mem_rsp_ready) |=> ($countones(rsp_valid) >= 1));

    // R8
    rsp0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid[0] && !rsp_ready[0]) |=> !rsp_valid[0]);

    // R8
    rsp1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid[1] && !rsp_ready[1]) |=> !rsp_valid[1]);
endmodule

bind reqfwd_top reqfwd_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_retry     (req_retry),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready)
);

// File: tb/reqfwd_top_tb.sv
`timescale 1ns/1ps
module reqfwd_top_tb;
    localparam int AW = 8;
    localparam int DW = 16;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          req_valid = '0;
    logic [1:0][AW-1:0]  req_addr = '0;
    logic [1:0]          req_wr = '0;
    logic [1:0][DW-1:0]  req_data = '0;
    logic [1:0]          req_ready, req_retry, rsp_valid, rsp_wr;
    logic [1:0][AW-1:0]  rsp_addr;
    logic [1:0][DW-1:0]  rsp_data;
    logic [1:0]          rsp_ready = 2'b11;
    logic [1:0]          rsp_retry = '0;
    logic                mem_req_valid, mem_req_wr, mem_rsp_ready;
    logic [AW-1:0]       mem_req_addr;
    logic [DW-1:0]       mem_req_data;
    logic                mem_req_ready = 1'b0;
    logic                mem_req_retry = 1'b0;
    logic                mem_rsp_valid = 1'b0;
    logic [AW-1:0]       mem_rsp_addr = '0;
    logic                mem_rsp_wr = 1'b0;
    logic [DW-1:0]       mem_rsp_data = '0;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] owed = '0;

    always #4 clk = ~clk;

    reqfwd_top #(.ADDR_W(AW), .DATA_W(DW)) u_dut (.*);

    task automatic chk(input string r, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] mem_read(input logic [AW-1:0] a);
        return DW'(a) * 16'd7 + 16'd1;
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // p: 0 instr only, 1 data only, 2 both; keep: leave a refused response held
    task automatic txn(input int p, input bit mref, input bit rref, input bit wr,
                       input int idx, input bit keep);
        int win;
        logic [AW-1:0] a;
        logic [DW-1:0] d, rd;
        win = (p == 0) ? 0 : 1;
        a = AW'(idx * 17 + 5);
        d = DW'(idx * 29 + 3);
        @(posedge clk); #1;
        for (int k = 0; k < 2; k++) begin
            req_addr[k] = a + AW'(k);
            req_data[k] = d + DW'(k);
            req_wr[k]   = wr;
        end
        req_valid = (p == 0) ? 2'b01 : (p == 1) ? 2'b10 : 2'b11;
        @(negedge clk);
        chk("R2 accept", req_ready[win], 1);
        if (p == 2) begin
            chk("R3 instr refused", req_ready[0], 0);
            owed[0] = 1'b1;
        end
        @(posedge clk); #1;
        req_valid = '0;
        mem_req_ready = !mref;
        @(negedge clk);
        chk("R2 fwd valid", mem_req_valid, 1);
        chk("R2 fwd addr", mem_req_addr, a + AW'(win));
        chk("R2 fwd data", mem_req_data, d + DW'(win));
        chk("R2 fwd wr", mem_req_wr, wr);
        chk("R4 blocked", req_ready, 0);
        if (mref) begin
            @(posedge clk); #1;
            @(negedge clk);
            chk("R6 held", mem_req_valid, 0);
            @(posedge clk); #1;
            mem_req_retry = 1'b1;
            mem_req_ready = 1'b1;
            @(negedge clk);
            chk("R6 retry cycle", mem_req_valid, 0);
            @(posedge clk); #1;
            mem_req_retry = 1'b0;
            @(negedge clk);
            chk("R6 resend", mem_req_valid, 1);
            chk("R6 resend addr", mem_req_addr, a + AW'(win));
        end
        @(posedge clk); #1;
        mem_req_ready = 1'b0;
        if (p != 2) begin
            req_valid[1-win] = 1'b1;
            @(negedge clk);
            chk("R4 refused while blocked", req_ready[1-win], 0);
            owed[1-win] = 1'b1;
            @(posedge clk); #1;
            req_valid = '0;
        end
        rd = wr ? (d + DW'(win)) : mem_read(a + AW'(win));
        mem_rsp_valid = 1'b1;
        mem_rsp_addr  = a + AW'(win);
        mem_rsp_wr    = wr;
        mem_rsp_data  = rd;
        @(negedge clk);
        chk("R10 rsp ready", mem_rsp_ready, 1);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
        rsp_ready[win] = !rref;
        @(negedge clk);
        chk("R7 routed", rsp_valid[win], 1);
        chk("R7 other idle", rsp_valid[1-win], 0);
        chk("R7 data", rsp_data[win], rd);
        chk("R7 addr", rsp_addr[win], a + AW'(win));
        chk("R5 retry pulse", req_retry, owed);
        chk("R9 unblocked", req_ready, 2'b11);
        owed = '0;
        if (rref) begin
            @(posedge clk); #1;
            @(negedge clk);
            chk("R8 held", rsp_valid[win], 0);
            chk("R5 single pulse", req_retry, 0);
            if (keep) return;
            @(posedge clk); #1;
            rsp_retry[win] = 1'b1;
            rsp_ready[win] = 1'b1;
            @(negedge clk);
            chk("R8 retry cycle", rsp_valid[win], 0);
            @(posedge clk); #1;
            rsp_retry[win] = 1'b0;
            @(negedge clk);
            chk("R8 resend", rsp_valid[win], 1);
            chk("R8 resend data", rsp_data[win], rd);
        end
        @(posedge clk); #1;
        rsp_ready = 2'b11;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready", req_ready, 2'b11);
        chk("R1 mem valid", mem_req_valid, 0);
        chk("R1 rsp valid", rsp_valid, 0);
        chk("R1 retry", req_retry, 0);
        chk("R10 idle not ready", mem_rsp_ready, 0);

        for (int p = 0; p < 3; p++)
            for (int m = 0; m < 2; m++)
                for (int r = 0; r < 2; r++)
                    for (int w = 0; w < 2; w++)
                        txn(p, m[0], r[0], w[0], p * 8 + m * 4 + r * 2 + w, 1'b0);

        // R10: data port response held, second data request awaits delivery
        txn(1, 1'b0, 1'b1, 1'b0, 30, 1'b1);
        @(posedge clk); #1;
        req_valid = 2'b10;
        req_addr[1] = 8'h3c;
        @(negedge clk);
        chk("R9 accept while rsp held", req_ready[1], 1);
        @(posedge clk); #1;
        req_valid = '0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        chk("R2 second fwd", mem_req_valid, 1);
        @(posedge clk); #1;
        mem_req_ready = 1'b0;
        @(negedge clk);
        chk("R10 held blocks rsp", mem_rsp_ready, 0);
        @(posedge clk); #1;
        rsp_retry[1] = 1'b1;
        rsp_ready[1] = 1'b1;
        @(negedge clk);
        chk("R10 still held", mem_rsp_ready, 0);
        @(posedge clk); #1;
        rsp_retry[1] = 1'b0;
        @(negedge clk);
        chk("R8 resend old", rsp_valid[1], 1);
        chk("R10 offering", mem_rsp_ready, 0);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b1;
        mem_rsp_addr  = 8'h3c;
        mem_rsp_data  = mem_read(8'h3c);
        @(negedge clk);
        chk("R10 freed", mem_rsp_ready, 1);
        @(posedge clk); #1;
        mem_rsp_valid = 1'b0;
        @(negedge clk);
        chk("R7 new rsp", rsp_valid[1], 1);
        chk("R7 new data", rsp_data[1], mem_read(8'h3c));
        @(posedge clk); #1;
        report();
    end
endmodule